// File: doc/BRIEF.md
# Load-Use Stall Scoreboard

This block is the timing side of a simple in-order pipeline. It produces a cycle count for each issued instruction and keeps the running statistics. It does not decode instructions and has no datapath. Each strobe of `in_valid` presents one instruction:

- the unit class of the instruction;
- up to two source register operands, each with its own valid flag;
- a destination register;
- a base cycle count;
- a branch-taken flag;
- a delay-slot attribute.

The block adds a stall cycle for every source operand that reads a register loaded by the instruction just before. It adds one more cycle when a branch is taken and has no delay slot. The resulting count is shown on `insn_cycles` and added to the running totals.

Only one instruction of load history is kept. While an instruction runs, the block notes the destination of a load. When that instruction completes, the note replaces the load history, so the history always reflects the previous instruction and nothing older. Idle cycles between strobes do not change it.

Top module: `lsb_scoreboard`

## Requirements
- R1: A synchronous active-high `rst` sets `insn_cycles`, every counter and the load history to zero. Reset takes priority over a strobe in the same cycle.
- R2: A valid instruction of class load (code 2) records its destination register for the next valid instruction only. Any valid instruction of another class clears the record.
- R3: Each checked source operand whose valid flag is set and whose register is in the record adds one cycle to the instruction and adds one to `load_stalls`. An operand with its valid flag low is never checked, whatever its index.
- R4: The class decides which operands are checked. Exec (code 0) and store (code 3) check operand A and operand B. Load (code 2) and branch (code 1) check operand A only.
- R5: Multi-register load (code 4), multi-register store (code 5) and the unused codes 6 and 7 cost exactly the base count. They check no operand.
- R6: A branch with `br_taken` high and `has_delay_slot` low costs one extra cycle and adds one to `branch_stalls`. A taken branch with a delay slot has no penalty.
- R7: Every branch adds one to `taken_count` if taken or to `untaken_count` if not. Other classes change neither counter.
- R8: On the clock edge that accepts an instruction, `insn_cycles` takes its final count and `total_cycles` grows by that count.
- R9: Every counter saturates at all ones and never wraps.
- R10: In a cycle with `in_valid` low, no output and no part of the load history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One instruction presented this cycle |
| in_class | input | 3 | Unit class code |
| src_a_valid | input | 1 | Operand A present |
| src_a_idx | input | $clog2(NREG) | Operand A register (load base, branch operand) |
| src_b_valid | input | 1 | Operand B present |
| src_b_idx | input | $clog2(NREG) | Operand B register |
| dst_idx | input | $clog2(NREG) | Destination register of a load |
| base_cycles | input | BASE_W | Base cycle count of the instruction |
| br_taken | input | 1 | Branch taken |
| has_delay_slot | input | 1 | Branch has a delay slot |
| insn_cycles | output | BASE_W+2 | Final count of the last accepted instruction |
| total_cycles | output | CNT_W | Running cycle total |
| load_stalls | output | CNT_W | Load-use stall cycles |
| branch_stalls | output | CNT_W | Taken-branch penalty cycles |
| taken_count | output | CNT_W | Taken branches |
| untaken_count | output | CNT_W | Not-taken branches |

## Verification
The hardest condition to reach is the load history surviving or being cleared at the right moment. Two cases matter: a record that should persist across idle cycles, and a record that a multi-register or reset cycle should erase. The history can only be seen through the stall it causes one instruction later.

The stimulus therefore places a load and then a probe instruction that reads the loaded register. Between the two it inserts, in turn:

- idle cycles;
- a multi-register instruction;
- a reset;
- a load that reads its own destination.

Each probe's count then shows whether the record was kept. Saturation is reached by building the bench with narrow counters and issuing maximum base counts.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  typedef enum logic [2:0] {
    CLS_EXEC   = 3'd0,
    CLS_BRANCH = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_MLOAD  = 3'd4,
    CLS_MSTORE = 3'd5
  } unit_cls_e;

  // Operand A is checked by every single-register class.
  function automatic logic reads_a(input logic [2:0] cls);
    return (cls == CLS_EXEC) || (cls == CLS_BRANCH) ||
           (cls == CLS_LOAD) || (cls == CLS_STORE);
  endfunction

  // Operand B is only checked by exec and store.
  function automatic logic reads_b(input logic [2:0] cls);
    return (cls == CLS_EXEC) || (cls == CLS_STORE);
  endfunction

  function automatic logic is_branch(input logic [2:0] cls);
    return cls == CLS_BRANCH;
  endfunction

  function automatic logic is_load(input logic [2:0] cls);
    return cls == CLS_LOAD;
  endfunction

  // Number of stall cycles contributed by the two operand hits.
  function automatic logic [1:0] stall_sum(input logic hit_a, input logic hit_b);
    return {1'b0, hit_a} + {1'b0, hit_b};
  endfunction

endpackage

// File: rtl/lsb_sat_counter.sv
module lsb_sat_counter #(
  parameter int W  = 32,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [IW-1:0] amt,
  output logic [W-1:0]  cnt
);
  localparam int PADW = W + 1 - IW;

  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    sum = {1'b0, cnt} + {{PADW{1'b0}}, amt};
    nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= nxt;
  end
endmodule

// File: rtl/lsb_load_mask.sv
module lsb_load_mask #(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             load_insn,
  input  logic [IDX_W-1:0] dst_idx,
  output logic [NREG-1:0]  active
);
  logic [NREG-1:0] pending;

  // Pending mask starts empty for every instruction; only a load sets a bit.
  always_comb begin
    pending = '0;
    if (load_insn) pending[dst_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         active <= '0;
    else if (commit) active <= pending;
  end
endmodule

// File: rtl/lsb_operand_check.sv
module lsb_operand_check
  import lsb_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [2:0]       cls,
  input  logic             a_vld,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_vld,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [NREG-1:0]  active,
  output logic             hit_a,
  output logic             hit_b
);
  always_comb begin
    hit_a = reads_a(cls) && a_vld && active[a_idx];
    hit_b = reads_b(cls) && b_vld && active[b_idx];
  end
endmodule

// File: rtl/lsb_cost_calc.sv
module lsb_cost_calc
  import lsb_pkg::*;
#(
  parameter int BASE_W = 8,
  localparam int CYC_W = BASE_W + 2
) (
  input  logic [2:0]        cls,
  input  logic [BASE_W-1:0] base,
  input  logic              taken,
  input  logic              dslot,
  input  logic              hit_a,
  input  logic              hit_b,
  output logic              br_pen,
  output logic [CYC_W-1:0]  cycles
);
  function automatic logic [CYC_W-1:0] final_cost(
    input logic [BASE_W-1:0] b,
    input logic [1:0]        stalls,
    input logic              pen
  );
    return {2'b00, b} + {{(CYC_W-2){1'b0}}, stalls} + {{(CYC_W-1){1'b0}}, pen};
  endfunction

  always_comb begin
    br_pen = is_branch(cls) && taken && !dslot;
    cycles = final_cost(base, stall_sum(hit_a, hit_b), br_pen);
  end
endmodule

// File: rtl/lsb_scoreboard.sv
module lsb_scoreboard
  import lsb_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int CYC_W = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic              src_a_valid,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic              src_b_valid,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [BASE_W-1:0] base_cycles,
  input  logic              br_taken,
  input  logic              has_delay_slot,
  output logic [CYC_W-1:0]  insn_cycles,
  output logic [CNT_W-1:0]  total_cycles,
  output logic [CNT_W-1:0]  load_stalls,
  output logic [CNT_W-1:0]  branch_stalls,
  output logic [CNT_W-1:0]  taken_count,
  output logic [CNT_W-1:0]  untaken_count
);
  localparam int NCNT = 5;
  localparam int C_TOT = 0, C_LDS = 1, C_BRS = 2, C_TKN = 3, C_UTK = 4;

  logic [NREG-1:0]  active_mask;
  logic             hit_a, hit_b, br_pen;
  logic [CYC_W-1:0] cost;

  // Named events for the checker.
  logic ev_hit_a, ev_hit_b, ev_br_pen, ev_taken, ev_untaken;

  lsb_load_mask #(.NREG(NREG)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .commit    (in_valid),
    .load_insn (is_load(in_class)),
    .dst_idx   (dst_idx),
    .active    (active_mask)
  );

  lsb_operand_check #(.NREG(NREG)) u_ops (
    .cls    (in_class),
    .a_vld  (src_a_valid),
    .a_idx  (src_a_idx),
    .b_vld  (src_b_valid),
    .b_idx  (src_b_idx),
    .active (active_mask),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );

  lsb_cost_calc #(.BASE_W(BASE_W)) u_cost (
    .cls    (in_class),
    .base   (base_cycles),
    .taken  (br_taken),
    .dslot  (has_delay_slot),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .br_pen (br_pen),
    .cycles (cost)
  );

  assign ev_hit_a   = in_valid && hit_a;
  assign ev_hit_b   = in_valid && hit_b;
  assign ev_br_pen  = in_valid && br_pen;
  assign ev_taken   = in_valid && is_branch(in_class) && br_taken;
  assign ev_untaken = in_valid && is_branch(in_class) && !br_taken;

  logic [CYC_W-1:0] amt [NCNT];
  logic [CNT_W-1:0] cnt [NCNT];

  always_comb begin
    amt[C_TOT] = cost;
    amt[C_LDS] = {{(CYC_W-2){1'b0}}, stall_sum(hit_a, hit_b)};
    amt[C_BRS] = {{(CYC_W-1){1'b0}}, br_pen};
    amt[C_TKN] = {{(CYC_W-1){1'b0}}, is_branch(in_class) && br_taken};
    amt[C_UTK] = {{(CYC_W-1){1'b0}}, is_branch(in_class) && !br_taken};
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    lsb_sat_counter #(.W(CNT_W), .IW(CYC_W)) u_sat (
      .clk (clk),
      .rst (rst),
      .en  (in_valid),
      .amt (amt[g]),
      .cnt (cnt[g])
    );
  end

  assign total_cycles  = cnt[C_TOT];
  assign load_stalls   = cnt[C_LDS];
  assign branch_stalls = cnt[C_BRS];
  assign taken_count   = cnt[C_TKN];
  assign untaken_count = cnt[C_UTK];

  always_ff @(posedge clk) begin
    if (rst)           insn_cycles <= '0;
    else if (in_valid) insn_cycles <= cost;
  end
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32,
  parameter int CYC_W  = BASE_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_class,
  input logic [BASE_W-1:0] base_cycles,
  input logic              br_taken,
  input logic              has_delay_slot,
  input logic [CYC_W-1:0]  insn_cycles,
  input logic [CNT_W-1:0]  total_cycles,
  input logic [CNT_W-1:0]  load_stalls,
  input logic [CNT_W-1:0]  taken_count,
  input logic [CNT_W-1:0]  untaken_count,
  input logic              ev_hit_a,
  input logic              ev_hit_b,
  input logic              ev_br_pen
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (total_cycles == '0 && insn_cycles == '0 && load_stalls == '0));

  a_r4_b_only_exec_store: assert property (@(posedge clk) disable iff (rst)
    ev_hit_b |-> (in_valid && (in_class == 3'd0 || in_class == 3'd3)));

  a_r4_a_needs_checker_class: assert property (@(posedge clk) disable iff (rst)
    ev_hit_a |-> (in_class <= 3'd3));

  a_r5_multi_base_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class >= 3'd4) |=> (insn_cycles == $past(base_cycles)));

  a_r6_penalty_cond: assert property (@(posedge clk) disable iff (rst)
    ev_br_pen |-> (in_class == 3'd1 && br_taken && !has_delay_slot));

  a_r7_one_branch_count: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0({taken_count != $past(taken_count),
                       untaken_count != $past(untaken_count)}));

  a_r8_not_below_base: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (insn_cycles >= $past(base_cycles)));

  a_r9_total_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (total_cycles >= $past(total_cycles)));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(total_cycles) && $stable(insn_cycles) && $stable(load_stalls)));
endmodule

bind lsb_scoreboard lsb_checker #(.BASE_W(BASE_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_class       (in_class),
  .base_cycles    (base_cycles),
  .br_taken       (br_taken),
  .has_delay_slot (has_delay_slot),
  .insn_cycles    (insn_cycles),
  .total_cycles   (total_cycles),
  .load_stalls    (load_stalls),
  .taken_count    (taken_count),
  .untaken_count  (untaken_count),
  .ev_hit_a       (ev_hit_a),
  .ev_hit_b       (ev_hit_b),
  .ev_br_pen      (ev_br_pen)
);

// File: tb/tb_lsb_scoreboard.sv
`timescale 1ns/1ps
module tb_lsb_scoreboard;
  localparam int CW  = 12;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, in_valid, av, bv, tk, ds;
  logic [2:0] cls;
  logic [3:0] ai, bi, dst;
  logic [7:0] base;
  logic [9:0] insn_cycles;
  logic [CW-1:0] total, lds, brs, tkc, utc;

  lsb_scoreboard #(.NREG(16), .BASE_W(8), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(cls),
    .src_a_valid(av), .src_a_idx(ai), .src_b_valid(bv), .src_b_idx(bi),
    .dst_idx(dst), .base_cycles(base), .br_taken(tk), .has_delay_slot(ds),
    .insn_cycles(insn_cycles), .total_cycles(total), .load_stalls(lds),
    .branch_stalls(brs), .taken_count(tkc), .untaken_count(utc)
  );

  typedef struct packed {
    logic [2:0] cls; logic av; logic [3:0] ai; logic bv; logic [3:0] bi;
    logic [3:0] dst; logic [7:0] base; logic tk; logic ds;
    logic [9:0] ecyc; logic [1:0] els; logic ebs;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd2,1'b1,4'd2, 1'b0,4'd0, 4'd5, 8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd0,1'b1,4'd5, 1'b1,4'd5, 4'd0, 8'd1,1'b0,1'b0, 10'd3,2'd2,1'b0},
    '{3'd0,1'b1,4'd5, 1'b1,4'd6, 4'd0, 8'd1,1'b0,1'b0, 10'd1,2'd0,1'b0},
    '{3'd2,1'b1,4'd3, 1'b0,4'd0, 4'd7, 8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd3,1'b1,4'd1, 1'b1,4'd7, 4'd0, 8'd1,1'b0,1'b0, 10'd2,2'd1,1'b0},
    '{3'd2,1'b1,4'd0, 1'b0,4'd0, 4'd9, 8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd2,1'b1,4'd9, 1'b1,4'd9, 4'd9, 8'd2,1'b0,1'b0, 10'd3,2'd1,1'b0},
    '{3'd1,1'b1,4'd9, 1'b1,4'd9, 4'd0, 8'd1,1'b1,1'b0, 10'd3,2'd1,1'b1},
    '{3'd1,1'b0,4'd0, 1'b0,4'd0, 4'd0, 8'd1,1'b1,1'b1, 10'd1,2'd0,1'b0},
    '{3'd1,1'b0,4'd0, 1'b0,4'd0, 4'd0, 8'd1,1'b0,1'b0, 10'd1,2'd0,1'b0},
    '{3'd2,1'b1,4'd4, 1'b0,4'd0, 4'd12,8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd4,1'b1,4'd12,1'b1,4'd12,4'd0, 8'd5,1'b0,1'b0, 10'd5,2'd0,1'b0},
    '{3'd0,1'b1,4'd12,1'b0,4'd0, 4'd0, 8'd1,1'b0,1'b0, 10'd1,2'd0,1'b0},
    '{3'd2,1'b1,4'd1, 1'b0,4'd0, 4'd3, 8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd0,1'b0,4'd3, 1'b1,4'd4, 4'd0, 8'd1,1'b0,1'b0, 10'd1,2'd0,1'b0},
    '{3'd2,1'b1,4'd0, 1'b0,4'd0, 4'd3, 8'd2,1'b0,1'b0, 10'd2,2'd0,1'b0},
    '{3'd5,1'b1,4'd3, 1'b1,4'd3, 4'd0, 8'd4,1'b0,1'b0, 10'd4,2'd0,1'b0},
    '{3'd2,1'b1,4'd0, 1'b0,4'd0, 4'd15,8'd3,1'b0,1'b0, 10'd3,2'd0,1'b0},
    '{3'd1,1'b1,4'd15,1'b0,4'd0, 4'd0, 8'd2,1'b1,1'b1, 10'd3,2'd1,1'b0}
  };

  int n_run = 0, n_fail = 0;
  int e_tot, e_ls, e_bs, e_tk, e_ut;
  bit finished = 0;

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_counters(input string tag);
    chk({tag, " total_cycles (R8)"}, int'(total), e_tot);
    chk({tag, " load_stalls (R3)"}, int'(lds), e_ls);
    chk({tag, " branch_stalls (R6)"}, int'(brs), e_bs);
    chk({tag, " taken_count (R7)"}, int'(tkc), e_tk);
    chk({tag, " untaken_count (R7)"}, int'(utc), e_ut);
  endtask

  task automatic drive(input vec_t v);
    cls = v.cls; av = v.av; ai = v.ai; bv = v.bv; bi = v.bi;
    dst = v.dst; base = v.base; tk = v.tk; ds = v.ds; in_valid = 1'b1;
  endtask

  function automatic vec_t mk(input logic [2:0] c, input logic a_v, input logic [3:0] a_i,
                              input logic [3:0] d, input logic [7:0] b);
    vec_t v = '0;
    v.cls = c; v.av = a_v; v.ai = a_i; v.dst = d; v.base = b;
    return v;
  endfunction

  task automatic model_step(input int cyc, input int ls, input int bs, input vec_t v);
    e_tot = sat(e_tot + cyc);
    e_ls  = sat(e_ls + ls);
    e_bs  = sat(e_bs + bs);
    if (v.cls == 3'd1) begin
      if (v.tk) e_tk = sat(e_tk + 1);
      else      e_ut = sat(e_ut + 1);
    end
  endtask

  task automatic clear_model();
    e_tot = 0; e_ls = 0; e_bs = 0; e_tk = 0; e_ut = 0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; drive(mk(3'd2, 1'b1, 4'd1, 4'd1, 8'd9)); in_valid = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 insn_cycles after reset", int'(insn_cycles), 0);
    chk_counters("R1 reset");

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      model_step(int'(VEC[i].ecyc), int'(VEC[i].els), int'(VEC[i].ebs), VEC[i]);
      chk($sformatf("R8 vec%0d insn_cycles", i), int'(insn_cycles), int'(VEC[i].ecyc));
      chk_counters($sformatf("vec%0d", i));
    end
    in_valid = 1'b0;

    // R10: a load record and outputs persist across idle cycles
    drive(mk(3'd2, 1'b1, 4'd0, 4'd2, 8'd2));
    @(negedge clk);
    model_step(2, 0, 0, mk(3'd2, 1'b1, 4'd0, 4'd2, 8'd2));
    in_valid = 1'b0; base = 8'd200; cls = 3'd0; av = 1'b1; ai = 4'd2;
    repeat (3) @(negedge clk);
    chk("R10 idle insn_cycles held", int'(insn_cycles), 2);
    chk_counters("R10 idle");
    drive(mk(3'd0, 1'b1, 4'd2, 4'd0, 8'd1));
    @(negedge clk);
    model_step(2, 1, 0, mk(3'd0, 1'b1, 4'd2, 4'd0, 8'd1));
    chk("R10 record kept over idle, R2", int'(insn_cycles), 2);
    chk_counters("R10 after idle");

    // R1: reset with a strobe pending clears the load record too
    drive(mk(3'd2, 1'b1, 4'd0, 4'd6, 8'd2));
    @(negedge clk);
    rst = 1'b1;
    drive(mk(3'd0, 1'b1, 4'd6, 4'd0, 8'd7));
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    in_valid = 1'b0;
    chk("R1 reset beats strobe insn_cycles", int'(insn_cycles), 0);
    chk_counters("R1 mid reset");
    drive(mk(3'd0, 1'b1, 4'd6, 4'd0, 8'd1));
    @(negedge clk);
    model_step(1, 0, 0, mk(3'd0, 1'b1, 4'd6, 4'd0, 8'd1));
    chk("R1 record cleared by reset", int'(insn_cycles), 1);
    chk_counters("R1 post reset");

    // R9: saturation of the narrow total counter
    for (int k = 0; k < 20; k++) begin
      drive(mk(3'd0, 1'b0, 4'd0, 4'd0, 8'd255));
      @(negedge clk);
      model_step(255, 0, 0, mk(3'd0, 1'b0, 4'd0, 4'd0, 8'd255));
    end
    in_valid = 1'b0;
    chk("R9 total saturated", int'(total), MAXC);
    chk("R9 model agrees", e_tot, MAXC);
    chk("R9 insn_cycles max base", int'(insn_cycles), 255);
    drive(mk(3'd0, 1'b0, 4'd0, 4'd0, 8'd3));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 no wrap", int'(total), MAXC);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule